// File: doc/BRIEF.md
# Power-Management Interrupt Event Aggregator

This block gathers interrupt requests from eight on-chip sources and folds them into one active-low power-management interrupt line. The sources are the floppy controller (0), serial port A (1), serial port B (2), the parallel port (3), the keyboard (4), the mouse (5) and two general-purpose inputs (6, 7). Each source has an enable bit. While a source is asserted and enabled, a per-source status bit is latched. That bit drops again when the source goes away, or when software issues a clear-all command.

The output runs in one of two modes. In level mode it stays low while any enabled status bit is set. In pulse mode it emits a fixed-width low pulse each time the aggregated event rises. Software reaches the block through a small synchronous register port with four byte-wide addresses: two control registers and two read-only status registers. Reads are combinational from the address.

Top module: `pmIntAggregator`

## Requirements
- R1: After reset `pmIntN` is 1, and all four registers read 0x00. The default mode is level.
- R2: Register address 0 holds the enables: bit i enables source i. A write sets all eight bits, and a read returns the last value written.
- R3: Register address 1 holds the mode in bit 6 (1 = pulse, 0 = level), and bit 6 reads back. Bits 7 and 5..0 of address 1 always read 0.
- R4: Status bit i is set at the clock edge that samples source i high with enable i set. Address 2 bits 3..0 show status of sources 0..3, and address 3 bits 3..0 show sources 4..7. Bits 7..4 of both addresses read 0.
- R5: A source that is asserted while its enable bit is 0 does not set its status bit.
- R6: A set status bit clears at the first edge that samples its source low. While the source stays high, the bit holds, even after its enable is cleared.
- R7: Writing address 1 with bit 7 = 1 clears every status bit at that edge, even if the sources are still active. A source that is still active and enabled sets its bit again at the following edge. Bit 6 of the same write is stored as the mode.
- R8: In level mode, `pmIntN` is low one cycle after any status bit with its enable set exists. It returns high one cycle after none exists, including when the enable is cleared while the status bit is held.
- R9: In pulse mode, `pmIntN` goes low one cycle after the aggregated event rises. It stays low for exactly 4 cycles and then returns high, even if the event stays active.
- R10: Writes to addresses 2 and 3 have no effect on the status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcReq | input | 8 | Synchronous interrupt requests, bit i = source i |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for read and write |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read data for `regAddr` |
| pmIntN | output | 1 | Active-low power-management interrupt |

## Verification
Embedded assertions check, on every cycle:
- that no status bit survives an edge that sampled its source low;
- that a clear-all leaves status empty;
- that no status bit rises without its enable;
- that the level-mode output follows the enabled event with one cycle of delay;
- that each event rise in pulse mode pulls the output low.

Other behaviour only shows up in the bench's sweeps:
- the exact width of the pulse and its end while the event persists;
- the split of status across the two read addresses;
- the reassertion after a clear-all;
- that writes to the status addresses change nothing.

The bench sweeps all 256 request patterns under several enable masks.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 2;
  localparam int MODE_BIT = 6;
  localparam int CLR_BIT  = 7;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT_L = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT_H = 2'd3;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic             ldEnable;
    logic             ldMode;
    logic             clrAll;
    logic [REG_W-1:0] wrData;
  } regStrobe_t;
endpackage

// File: rtl/pmiControl.sv
module pmiControl
  import pmi_pkg::*;
#(
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              eventAny,
  input  logic              modePulse,
  output regStrobe_t        strobe,
  output logic              pmIntN
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic             evPrev;
  logic             outLow;
  logic [CNT_W-1:0] pulseCnt;
  logic             evRise;

  // Register write decode
  always_comb begin
    strobe.ldEnable = regWrEn && (regAddr == ADDR_ENABLE);
    strobe.ldMode   = regWrEn && (regAddr == ADDR_MODE);
    strobe.clrAll   = strobe.ldMode && regWrData[CLR_BIT];
    strobe.wrData   = regWrData;
  end

  assign evRise = eventAny && !evPrev;

  // Output sequencer: level follow or fixed-width pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evPrev   <= 1'b0;
      outLow   <= 1'b0;
      pulseCnt <= '0;
    end else begin
      evPrev <= eventAny;
      if (!modePulse) begin
        outLow   <= eventAny;
        pulseCnt <= '0;
      end else if (evRise) begin
        outLow   <= 1'b1;
        pulseCnt <= CNT_W'(PULSE_LEN - 1);
      end else if (pulseCnt != '0) begin
        outLow   <= 1'b1;
        pulseCnt <= pulseCnt - 1'b1;
      end else begin
        outLow <= 1'b0;
      end
    end
  end

  assign pmIntN = !outLow;

  a_r8_level_follow: assert property (@(posedge clk) disable iff (!rstN)
    !modePulse |=> (pmIntN == !$past(eventAny)));

  a_r9_pulse_start: assert property (@(posedge clk) disable iff (!rstN)
    (modePulse && eventAny && !evPrev) |=> !pmIntN);
endmodule

// File: rtl/pmiDatapath.sv
module pmiDatapath
  import pmi_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  regStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  regAddr,
  output logic [REG_W-1:0]   rdData,
  output logic               eventAny,
  output logic               modePulse
);
  localparam int HALF = NUM_SRC / 2;

  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] statusQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ   <= '0;
      modePulse <= 1'b0;
    end else begin
      if (strobe.ldEnable) enableQ   <= strobe.wrData[NUM_SRC-1:0];
      if (strobe.ldMode)   modePulse <= strobe.wrData[MODE_BIT];
    end
  end

  // Per-source status latch: set on request+enable, drop when request goes away
  for (genvar i = 0; i < NUM_SRC; i++) begin : gStat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                statusQ[i] <= 1'b0;
      else if (strobe.clrAll)   statusQ[i] <= 1'b0;
      else if (!srcReq[i])      statusQ[i] <= 1'b0;
      else if (enableQ[i])      statusQ[i] <= 1'b1;
    end
  end

  assign eventAny = |(statusQ & enableQ);

  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_ENABLE: rdData[NUM_SRC-1:0] = enableQ;
      ADDR_MODE:   rdData[MODE_BIT]    = modePulse;
      ADDR_STAT_L: rdData[HALF-1:0]    = statusQ[HALF-1:0];
      ADDR_STAT_H: rdData[HALF-1:0]    = statusQ[NUM_SRC-1:HALF];
      default:     rdData = '0;
    endcase
  end

  a_r6_clear_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ~$past(srcReq)) == '0));

  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (statusQ == '0));

  a_r5_need_enable: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ~$past(statusQ) & ~$past(enableQ)) == '0));
endmodule

// File: rtl/pmIntAggregator.sv
module pmIntAggregator
  import pmi_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int PULSE_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  output logic               pmIntN
);
  regStrobe_t strobe;
  logic       eventAny;
  logic       modePulse;

  pmiControl #(.PULSE_LEN(PULSE_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .eventAny(eventAny), .modePulse(modePulse),
    .strobe(strobe), .pmIntN(pmIntN)
  );

  pmiDatapath #(.NUM_SRC(NUM_SRC)) uDp (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .strobe(strobe),
    .regAddr(regAddr), .rdData(regRdData), .eventAny(eventAny),
    .modePulse(modePulse)
  );
endmodule

// File: tb/sim_pmIntAggregator.sv
`timescale 1ns/1ps
module sim_pmIntAggregator;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] srcReq = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       pmIntN;
  int checkCnt = 0;
  int failCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmIntAggregator u0 (.clk(clk), .rstN(rstN), .srcReq(srcReq), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .pmIntN(pmIntN));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] enList [4];
    enList[0] = 8'hFF; enList[1] = 8'hA5; enList[2] = 8'h00; enList[3] = 8'h3C;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1 pmIntN", {7'd0, pmIntN}, 8'h01);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); check("R1 reg", v, 8'h00);
    end
    // R2 enable readback
    wr(2'd0, 8'h5A); rd(2'd0, v); check("R2 enable", v, 8'h5A);
    // R3 mode readback, other bits zero
    wr(2'd1, 8'h7F); rd(2'd1, v); check("R3 mode", v, 8'h40);
    wr(2'd1, 8'h00); rd(2'd1, v); check("R3 mode off", v, 8'h00);

    // R4 R5 R8 sweep: level mode, all request patterns under several masks
    for (int e = 0; e < 4; e++) begin
      wr(2'd0, enList[e]);
      for (int p = 0; p < 256; p++) begin
        logic [7:0] expS;
        srcReq = 8'd0; tick();
        tick();
        srcReq = p[7:0];
        expS = p[7:0] & enList[e];
        tick();
        rd(2'd2, v); check("R4 R5 status low", v, {4'd0, expS[3:0]});
        rd(2'd3, v); check("R4 R5 status high", v, {4'd0, expS[7:4]});
        tick();
        check("R8 level out", {7'd0, pmIntN}, {7'd0, (expS == 8'd0)});
      end
    end
    srcReq = 8'd0; tick(); tick();
    check("R8 level release", {7'd0, pmIntN}, 8'h01);

    // R6 hold with enable cleared, R8 drop on enable clear
    wr(2'd0, 8'h04);
    srcReq = 8'h04; tick(); tick();
    wr(2'd0, 8'h00);
    rd(2'd2, v); check("R6 hold", v, 8'h04);
    tick();
    check("R8 enable cleared", {7'd0, pmIntN}, 8'h01);
    srcReq = 8'h00; tick();
    rd(2'd2, v); check("R6 drop", v, 8'h00);

    // R10 writes to status ignored
    wr(2'd0, 8'h80); srcReq = 8'h80; tick();
    wr(2'd2, 8'hFF); wr(2'd3, 8'h00);
    rd(2'd3, v); check("R10 status high kept", v, 8'h08);
    rd(2'd2, v); check("R10 status low kept", v, 8'h00);

    // R7 clear-all while source active
    wr(2'd1, 8'h80);
    rd(2'd3, v); check("R7 cleared", v, 8'h00);
    rd(2'd1, v); check("R7 clear reads 0", v, 8'h00);
    tick();
    rd(2'd3, v); check("R7 re-set", v, 8'h08);
    wr(2'd1, 8'hC0);
    rd(2'd1, v); check("R7 mode kept", v, 8'h40);
    srcReq = 8'h00; tick(); tick(); tick(); tick(); tick(); tick();

    // R9 pulse mode: width 4, ends while event persists
    wr(2'd0, 8'h01);
    srcReq = 8'h01;
    for (int k = 1; k <= 9; k++) begin
      tick();
      check("R9 pulse", {7'd0, pmIntN}, (k >= 2 && k <= 5) ? 8'h00 : 8'h01);
    end
    // R9 second rise gives a second pulse
    srcReq = 8'h00; tick(); tick();
    srcReq = 8'h01;
    for (int k = 1; k <= 7; k++) begin
      tick();
      check("R9 second pulse", {7'd0, pmIntN}, (k >= 2 && k <= 5) ? 8'h00 : 8'h01);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule